// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of an asynchronous, byte-wide parallel flash device. It turns one high-level request into the run of bus cycles the device expects. Four requests exist: read the identifier, erase one sector, erase the whole device, and program one byte. Each request starts with a two-write unlock preamble. After that come the command bytes for the chosen operation.

A request enters on a valid/ready handshake as an operation code, a target address and a data byte. The block then drives the flash address, the outgoing data, an active-low write strobe and an active-low read strobe. Every strobe lasts one clock, and a fixed idle gap of `GAP_CYCLES` clocks separates consecutive strobes. After an erase or a program, the block polls the device until it reports ready. When the request ends, the block pulses an acknowledge that carries a two-bit status. After an identifier read, the two identifier bytes stay on their outputs.

Top module: `flash_cmd_sequencer`

## Requirements
- R1: After reset, `reqReady` is high, `ackValid` is low, and both `flashWeN` and `flashOeN` are high. Both strobes stay high whenever the block is idle.
- R2: Operation code 0 (identifier read) performs these bus cycles in order:
  - write 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0x90 to 0x5555;
  - read offset 0 and latch it on `idMfr`, then read offset 1 and latch it on `idDev`;
  - write 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xF0 to 0x5555.
  It ends with status 0.
- R3: Operation code 1 (sector erase) performs these writes in order:
  - 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555;
  - 0xAA to 0x5555, 0x55 to 0x2AAA;
  - 0x30 to the request address.
  It then polls the request address until ready, and ends with status 0.
- R4: Operation code 2 (chip erase) performs the same five writes as R3, then writes 0x10 to 0x5555. It polls offset 0 until ready, and ends with status 0.
- R5: Operation code 3 (byte program) performs these cycles in order:
  - a blank-check read of the target;
  - writes of 0xAA to 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555;
  - a write of the data byte to the target.
  It then polls the target until ready, reads the target once more, and ends with status 0 if that byte equals the data.
- R6: A program request whose data byte is 0xFF issues no bus cycle. Its `ackValid` rises on the cycle after acceptance, with status 0.
- R7: If the blank-check read of a program returns anything other than 0xFF, the request ends with status 1 and issues no write.
- R8: If the final read-back of a program differs from the data byte, the request ends with status 2.
- R9: If `MAX_POLLS` consecutive poll reads pass without two equal bit-6 values in a row, the request ends with status 3. No read-back follows.
- R10: Each strobe is one clock wide, and `flashWeN` and `flashOeN` are never low together. Within a request, successive strobes begin exactly `GAP_CYCLES`+1 clocks apart.
- R11: `reqReady` drops in the cycle after a request is accepted and stays low until the acknowledge. `reqValid` has no effect while `reqReady` is low. `ackValid` is high for exactly one cycle, and `reqReady` returns in the cycle after it.
- R12: Polling stops on the first poll read whose data bit 6 equals bit 6 of the poll read just before it. The next bus cycle is then the following step of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and accepting a request |
| reqOp | input | 2 | 0 identifier, 1 sector erase, 2 chip erase, 3 program |
| reqAddr | input | ADDR_W | Target address (sector base or byte address) |
| reqData | input | 8 | Byte to program |
| ackValid | output | 1 | One-cycle completion pulse |
| ackStatus | output | 2 | 0 ok, 1 not blank, 2 verify mismatch, 3 poll timeout |
| idMfr | output | 8 | Identifier byte read at offset 0 |
| idDev | output | 8 | Identifier byte read at offset 1 |
| flashAddr | output | ADDR_W | Flash address bus |
| flashDout | output | 8 | Data driven to the flash on writes |
| flashDin | input | 8 | Data returned by the flash on reads |
| flashWeN | output | 1 | Active-low write strobe |
| flashOeN | output | 1 | Active-low read strobe |

## Verification
A small device model in the bench logs every write and counts every read. It interprets the command sequences and runs a settable number of busy reads with a toggling bit 6. A normal program with a data value whose bit 6 is clear fixes the exact number of poll reads, and so separates correct ready detection from early or late completion. Three program cases separate the 0xFF skip, the not-blank abort and the verify mismatch from one another:
- a 0xFF byte;
- a byte over an already programmed location;
- a program with a fault injected into the model.

A sector erase next to a programmed byte in another sector shows that only the addressed sector is affected. A model that never goes ready shows that the poll limit is exact.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam int IDX_W = 4;

  localparam logic [15:0] UNLOCK_ADDR1 = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR2 = 16'h2AAA;
  localparam logic [7:0]  UNLOCK_BYTE1 = 8'hAA;
  localparam logic [7:0]  UNLOCK_BYTE2 = 8'h55;
  localparam logic [7:0]  CMD_ID_ENTER = 8'h90;
  localparam logic [7:0]  CMD_ID_LEAVE = 8'hF0;
  localparam logic [7:0]  CMD_ERASE_SETUP = 8'h80;
  localparam logic [7:0]  CMD_SECTOR_GO = 8'h30;
  localparam logic [7:0]  CMD_CHIP_GO = 8'h10;
  localparam logic [7:0]  CMD_PROGRAM = 8'hA0;
  localparam logic [7:0]  BLANK_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    OP_READ_ID      = 2'd0,
    OP_SECTOR_ERASE = 2'd1,
    OP_CHIP_ERASE   = 2'd2,
    OP_PROGRAM      = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_OK         = 2'd0,
    ST_NOT_BLANK  = 2'd1,
    ST_VERIFY_BAD = 2'd2,
    ST_TIMEOUT    = 2'd3
  } status_e;

  typedef enum logic [2:0] {
    K_WRITE, K_READ_MFR, K_READ_DEV, K_READ_BLANK, K_POLL, K_READ_CHECK, K_END
  } kind_e;

  typedef enum logic [2:0] {
    A_UNLOCK1, A_UNLOCK2, A_ZERO, A_ONE, A_TARGET
  } asel_e;

  // One bus step of a command sequence
  typedef struct packed {
    kind_e       kind;
    asel_e       asel;
    logic        useReq;   // drive the request data byte instead of cbyte
    logic [7:0]  cbyte;
  } step_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic wrStrobe;
    logic rdStrobe;
    logic capMfr;
    logic capDev;
    logic pollCap;
    logic gapLoad;
    logic gapTick;
  } ctl_t;

  function automatic step_t mkWr(asel_e a, logic [7:0] b);
    step_t s;
    s.kind = K_WRITE; s.asel = a; s.useReq = 1'b0; s.cbyte = b;
    return s;
  endfunction

  function automatic step_t mkRd(kind_e k, asel_e a);
    step_t s;
    s.kind = k; s.asel = a; s.useReq = 1'b0; s.cbyte = 8'h00;
    return s;
  endfunction

  // Sequence table: the step at position idx of operation op
  function automatic step_t stepOf(op_e op, logic [IDX_W-1:0] idx);
    step_t s;
    s = mkRd(K_END, A_ZERO);
    unique case (op)
      OP_READ_ID: begin
        case (idx)
          4'd0: s = mkWr(A_UNLOCK1, UNLOCK_BYTE1);
          4'd1: s = mkWr(A_UNLOCK2, UNLOCK_BYTE2);
          4'd2: s = mkWr(A_UNLOCK1, CMD_ID_ENTER);
          4'd3: s = mkRd(K_READ_MFR, A_ZERO);
          4'd4: s = mkRd(K_READ_DEV, A_ONE);
          4'd5: s = mkWr(A_UNLOCK1, UNLOCK_BYTE1);
          4'd6: s = mkWr(A_UNLOCK2, UNLOCK_BYTE2);
          4'd7: s = mkWr(A_UNLOCK1, CMD_ID_LEAVE);
          default: s = mkRd(K_END, A_ZERO);
        endcase
      end
      OP_SECTOR_ERASE, OP_CHIP_ERASE: begin
        case (idx)
          4'd0: s = mkWr(A_UNLOCK1, UNLOCK_BYTE1);
          4'd1: s = mkWr(A_UNLOCK2, UNLOCK_BYTE2);
          4'd2: s = mkWr(A_UNLOCK1, CMD_ERASE_SETUP);
          4'd3: s = mkWr(A_UNLOCK1, UNLOCK_BYTE1);
          4'd4: s = mkWr(A_UNLOCK2, UNLOCK_BYTE2);
          4'd5: s = (op == OP_SECTOR_ERASE) ? mkWr(A_TARGET, CMD_SECTOR_GO)
                                            : mkWr(A_UNLOCK1, CMD_CHIP_GO);
          4'd6: s = mkRd(K_POLL, (op == OP_SECTOR_ERASE) ? A_TARGET : A_ZERO);
          default: s = mkRd(K_END, A_ZERO);
        endcase
      end
      OP_PROGRAM: begin
        case (idx)
          4'd0: s = mkRd(K_READ_BLANK, A_TARGET);
          4'd1: s = mkWr(A_UNLOCK1, UNLOCK_BYTE1);
          4'd2: s = mkWr(A_UNLOCK2, UNLOCK_BYTE2);
          4'd3: s = mkWr(A_UNLOCK1, CMD_PROGRAM);
          4'd4: begin
            s = mkWr(A_TARGET, 8'h00);
            s.useReq = 1'b1;
          end
          4'd5: s = mkRd(K_POLL, A_TARGET);
          4'd6: s = mkRd(K_READ_CHECK, A_TARGET);
          default: s = mkRd(K_END, A_ZERO);
        endcase
      end
      default: s = mkRd(K_END, A_ZERO);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int GAP_CYCLES = 3,
  parameter int MAX_POLLS  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  step_t             step,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic [7:0]        flashDin,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashDout,
  output logic              flashWeN,
  output logic              flashOeN,
  output logic [7:0]        idMfr,
  output logic [7:0]        idDev,
  output logic              gapDone,
  output logic              blankOk,
  output logic              verifyOk,
  output logic              pollStable,
  output logic              pollExpired
);

  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);

  logic [ADDR_W-1:0] tgtAddr;
  logic [7:0]        tgtData;
  logic [GW-1:0]     gapCnt;
  logic [PW-1:0]     pollCnt;
  logic              prevB6;

  // Request capture, identifier latches and poll history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtAddr <= '0;
      tgtData <= '0;
      idMfr   <= '0;
      idDev   <= '0;
      pollCnt <= '0;
      prevB6  <= 1'b0;
    end else begin
      if (ctl.load) begin
        tgtAddr <= reqAddr;
        tgtData <= reqData;
        pollCnt <= '0;
        prevB6  <= 1'b0;
      end
      if (ctl.capMfr) idMfr <= flashDin;
      if (ctl.capDev) idDev <= flashDin;
      if (ctl.pollCap) begin
        prevB6  <= flashDin[6];
        pollCnt <= pollCnt + PW'(1);
      end
    end
  end

  // Inter-cycle spacing counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            gapCnt <= '0;
    else if (ctl.gapLoad) gapCnt <= GW'(GAP_CYCLES);
    else if (ctl.gapTick && gapCnt != '0) gapCnt <= gapCnt - GW'(1);
  end

  assign gapDone = (gapCnt <= GW'(1));

  // Bus address and data selection
  always_comb begin
    unique case (step.asel)
      A_UNLOCK1: flashAddr = ADDR_W'(UNLOCK_ADDR1);
      A_UNLOCK2: flashAddr = ADDR_W'(UNLOCK_ADDR2);
      A_ZERO:    flashAddr = '0;
      A_ONE:     flashAddr = ADDR_W'(1);
      A_TARGET:  flashAddr = tgtAddr;
      default:   flashAddr = '0;
    endcase
  end

  assign flashDout = step.useReq ? tgtData : step.cbyte;
  assign flashWeN  = ~ctl.wrStrobe;
  assign flashOeN  = ~ctl.rdStrobe;

  // Read-result flags
  assign blankOk     = (flashDin == BLANK_BYTE);
  assign verifyOk    = (flashDin == tgtData);
  assign pollStable  = (pollCnt != '0) && (flashDin[6] == prevB6);
  assign pollExpired = (pollCnt >= PW'(MAX_POLLS - 1));

endmodule

// File: rtl/fcs_control.sv
module fcs_control
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic [7:0] reqData,
  input  logic       gapDone,
  input  logic       blankOk,
  input  logic       verifyOk,
  input  logic       pollStable,
  input  logic       pollExpired,
  output ctl_t       ctl,
  output step_t      step,
  output logic       reqReady,
  output logic       ackValid,
  output logic [1:0] ackStatus
);

  typedef enum logic [1:0] {S_IDLE, S_STROBE, S_GAP, S_RESP} state_e;

  state_e              state;
  op_e                 opReg;
  logic [IDX_W-1:0]    idx;
  status_e             status;
  logic                finish;
  logic                isWrite;
  logic                skipReq;

  assign step    = stepOf(opReg, idx);
  assign isWrite = (step.kind == K_WRITE);
  assign skipReq = (op_e'(reqOp) == OP_PROGRAM) && (reqData == BLANK_BYTE);

  always_comb begin
    ctl          = '0;
    ctl.load     = (state == S_IDLE) && reqValid;
    ctl.wrStrobe = (state == S_STROBE) && isWrite;
    ctl.rdStrobe = (state == S_STROBE) && !isWrite;
    ctl.capMfr   = ctl.rdStrobe && (step.kind == K_READ_MFR);
    ctl.capDev   = ctl.rdStrobe && (step.kind == K_READ_DEV);
    ctl.pollCap  = ctl.rdStrobe && (step.kind == K_POLL);
    ctl.gapLoad  = (state == S_STROBE);
    ctl.gapTick  = (state == S_GAP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      opReg  <= OP_READ_ID;
      idx    <= '0;
      status <= ST_OK;
      finish <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (reqValid) begin
            opReg  <= op_e'(reqOp);
            idx    <= '0;
            status <= ST_OK;
            finish <= 1'b0;
            state  <= skipReq ? S_RESP : S_STROBE;
          end
        end
        S_STROBE: begin
          state <= S_GAP;
          case (step.kind)
            K_READ_BLANK: begin
              if (!blankOk) begin
                status <= ST_NOT_BLANK;
                finish <= 1'b1;
              end else begin
                idx <= idx + IDX_W'(1);
              end
            end
            K_POLL: begin
              if (pollStable) begin
                idx <= idx + IDX_W'(1);
              end else if (pollExpired) begin
                status <= ST_TIMEOUT;
                finish <= 1'b1;
              end
            end
            K_READ_CHECK: begin
              if (!verifyOk) status <= ST_VERIFY_BAD;
              idx <= idx + IDX_W'(1);
            end
            default: idx <= idx + IDX_W'(1);
          endcase
        end
        S_GAP: begin
          if (gapDone) state <= (finish || step.kind == K_END) ? S_RESP : S_STROBE;
        end
        S_RESP: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign reqReady  = (state == S_IDLE);
  assign ackValid  = (state == S_RESP);
  assign ackStatus = status;

endmodule

// File: rtl/flash_cmd_sequencer.sv
module flash_cmd_sequencer
  import fcs_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int GAP_CYCLES = 3,
  parameter int MAX_POLLS  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  output logic              ackValid,
  output logic [1:0]        ackStatus,
  output logic [7:0]        idMfr,
  output logic [7:0]        idDev,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        flashDout,
  input  logic [7:0]        flashDin,
  output logic              flashWeN,
  output logic              flashOeN
);

  ctl_t  ctl;
  step_t step;
  logic  gapDone, blankOk, verifyOk, pollStable, pollExpired;

  fcs_control u_control (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqOp(reqOp), .reqData(reqData),
    .gapDone(gapDone), .blankOk(blankOk), .verifyOk(verifyOk),
    .pollStable(pollStable), .pollExpired(pollExpired),
    .ctl(ctl), .step(step),
    .reqReady(reqReady), .ackValid(ackValid), .ackStatus(ackStatus)
  );

  fcs_datapath #(
    .ADDR_W(ADDR_W), .GAP_CYCLES(GAP_CYCLES), .MAX_POLLS(MAX_POLLS)
  ) u_datapath (
    .clk(clk), .rstN(rstN),
    .ctl(ctl), .step(step),
    .reqAddr(reqAddr), .reqData(reqData), .flashDin(flashDin),
    .flashAddr(flashAddr), .flashDout(flashDout),
    .flashWeN(flashWeN), .flashOeN(flashOeN),
    .idMfr(idMfr), .idDev(idDev),
    .gapDone(gapDone), .blankOk(blankOk), .verifyOk(verifyOk),
    .pollStable(pollStable), .pollExpired(pollExpired)
  );

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic [1:0] reqOp,
  input logic [7:0] reqData,
  input logic       ackValid,
  input logic [1:0] ackStatus,
  input logic       flashWeN,
  input logic       flashOeN
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (flashWeN && flashOeN && !ackValid));

  p_ff_skip_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp == 2'd3 && reqData == 8'hFF)
      |=> (ackValid && ackStatus == 2'd0));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashWeN && !flashOeN));

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!flashWeN || !flashOeN) |=> (flashWeN && flashOeN));

  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> (!ackValid && reqReady));

endmodule

bind flash_cmd_sequencer fcs_checker u_fcsChecker (
  .clk(clk), .rstN(rstN),
  .reqValid(reqValid), .reqReady(reqReady),
  .reqOp(reqOp), .reqData(reqData),
  .ackValid(ackValid), .ackStatus(ackStatus),
  .flashWeN(flashWeN), .flashOeN(flashOeN)
);

// File: tb/tb_flash_cmd_sequencer.sv
`timescale 1ns/1ps
module tb_flash_cmd_sequencer;

  localparam int AW    = 16;
  localparam int GAP   = 3;
  localparam int POLLS = 8;
  localparam logic [7:0] MFR = 8'hBF;
  localparam logic [7:0] DEV = 8'hD6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [1:0] reqOp = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0] reqData = 8'h00;
  logic ackValid;
  logic [1:0] ackStatus;
  logic [7:0] idMfr, idDev;
  logic [AW-1:0] flashAddr;
  logic [7:0] flashDout;
  logic [7:0] flashDin;
  logic flashWeN, flashOeN;

  always #2 clk = ~clk;

  flash_cmd_sequencer #(.ADDR_W(AW), .GAP_CYCLES(GAP), .MAX_POLLS(POLLS)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData),
    .ackValid(ackValid), .ackStatus(ackStatus), .idMfr(idMfr), .idDev(idDev),
    .flashAddr(flashAddr), .flashDout(flashDout), .flashDin(flashDin),
    .flashWeN(flashWeN), .flashOeN(flashOeN)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- flash device model ----------------
  logic [7:0] mem [256];
  logic idMode;
  int busyCnt;
  logic tog;
  logic stuck = 1'b0;
  logic fault = 1'b0;
  logic seenWr, seenRd;
  logic [AW-1:0] seenAddr;
  logic [7:0] seenData;
  logic [AW-1:0] hA [5];
  logic [7:0] hD [5];

  always_comb begin
    if (busyCnt > 0)                    flashDin = {1'b0, tog, 6'b0};
    else if (idMode && flashAddr == 0)  flashDin = MFR;
    else if (idMode && flashAddr == 1)  flashDin = DEV;
    else                                flashDin = mem[flashAddr[7:0]];
  end

  function automatic bit hist(input int i, input logic [15:0] a, input logic [7:0] d);
    return (hA[i] == a) && (hD[i] == d);
  endfunction

  function automatic bit eraseLead();
    return hist(0, 16'h2AAA, 8'h55) && hist(1, 16'h5555, 8'hAA) &&
           hist(2, 16'h5555, 8'h80) && hist(3, 16'h2AAA, 8'h55) &&
           hist(4, 16'h5555, 8'hAA);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
      idMode <= 1'b0; busyCnt <= 0; tog <= 1'b0;
      for (int i = 0; i < 5; i++) begin hA[i] <= '0; hD[i] <= '0; end
    end else begin
      if (seenRd && busyCnt > 0) begin
        tog <= ~tog;
        if (!stuck) busyCnt <= busyCnt - 1;
      end
      if (seenWr) begin
        if (hist(0, 16'h5555, 8'hA0) && hist(1, 16'h2AAA, 8'h55) && hist(2, 16'h5555, 8'hAA)) begin
          mem[seenAddr[7:0]] <= fault ? (seenData ^ 8'h01) : (mem[seenAddr[7:0]] & seenData);
          busyCnt <= 3; tog <= 1'b0;
        end else if (seenData == 8'h90 && seenAddr == 16'h5555 &&
                     hist(0, 16'h2AAA, 8'h55) && hist(1, 16'h5555, 8'hAA)) begin
          idMode <= 1'b1;
        end else if (seenData == 8'hF0) begin
          idMode <= 1'b0;
        end else if (seenData == 8'h30 && eraseLead()) begin
          for (int i = 0; i < 16; i++) mem[{seenAddr[7:4], i[3:0]}] <= 8'hFF;
          busyCnt <= 4; tog <= 1'b0;
        end else if (seenData == 8'h10 && seenAddr == 16'h5555 && eraseLead()) begin
          for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
          busyCnt <= 6; tog <= 1'b0;
        end
        for (int i = 4; i > 0; i--) begin hA[i] <= hA[i-1]; hD[i] <= hD[i-1]; end
        hA[0] <= seenAddr; hD[0] <= seenData;
      end
    end
  end

  // ---------------- bus monitor (mid-cycle) ----------------
  logic [AW-1:0] logA [64];
  logic [7:0] logD [64];
  int gapLog [256];
  int nWr = 0, nRd = 0, nStb = 0;
  int cyc = 0, lastStb = -1;

  always @(negedge clk) begin
    cyc++;
    seenWr <= !flashWeN;
    seenRd <= !flashOeN;
    seenAddr <= flashAddr;
    seenData <= flashDout;
    if (!flashWeN) begin
      if (nWr < 64) begin logA[nWr] = flashAddr; logD[nWr] = flashDout; end
      nWr++;
    end
    if (!flashOeN) nRd++;
    if (!flashWeN || !flashOeN) begin
      if (nStb < 256) gapLog[nStb] = (lastStb < 0) ? 0 : cyc - lastStb;
      nStb++;
      lastStb = cyc;
    end
  end

  // ---------------- request driver ----------------
  int wr0, rd0, stb0, lat;
  logic [1:0] lastStatus;

  task automatic runOp(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                       input bit junk);
    @(negedge clk);
    wr0 = nWr; rd0 = nRd; stb0 = nStb;
    reqOp = op; reqAddr = a; reqData = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R11 ready low after accept", reqReady, 0);
    lat = 1;
    while (!ackValid) begin
      if (junk && lat < 6) begin reqValid = 1'b1; reqOp = 2'd2; end
      else reqValid = 1'b0;
      @(negedge clk);
      lat++;
    end
    reqValid = 1'b0;
    lastStatus = ackStatus;
    @(negedge clk);
    check(!ackValid && reqReady, "R11 ack single cycle", ackValid, 0);
  endtask

  task automatic checkWr(input int i, input logic [15:0] a, input logic [7:0] d, input string tag);
    check(logA[wr0+i] == a && logD[wr0+i] == d, tag, {logA[wr0+i], logD[wr0+i]}, {a, d});
  endtask

  task automatic checkSpacing(input string tag);
    for (int i = stb0 + 1; i < nStb; i++)
      check(gapLog[i] == GAP + 1, tag, gapLog[i], GAP + 1);
  endtask

  task automatic t_reset();
    check(reqReady && !ackValid, "R1 reset ready/ack", {reqReady, ackValid}, 2'b10);
    check(flashWeN && flashOeN, "R1 reset strobes high", {flashWeN, flashOeN}, 2'b11);
  endtask

  task automatic t_readId();
    runOp(2'd0, 16'h0000, 8'h00, 1'b0);
    check(nWr - wr0 == 6, "R2 write count", nWr - wr0, 6);
    checkWr(0, 16'h5555, 8'hAA, "R2 unlock1");
    checkWr(1, 16'h2AAA, 8'h55, "R2 unlock2");
    checkWr(2, 16'h5555, 8'h90, "R2 entry");
    checkWr(3, 16'h5555, 8'hAA, "R2 exit unlock1");
    checkWr(4, 16'h2AAA, 8'h55, "R2 exit unlock2");
    checkWr(5, 16'h5555, 8'hF0, "R2 exit cmd");
    check(nRd - rd0 == 2, "R2 read count", nRd - rd0, 2);
    check(idMfr == MFR, "R2 manufacturer byte", idMfr, MFR);
    check(idDev == DEV, "R2 device byte", idDev, DEV);
    check(lastStatus == 2'd0, "R2 status", lastStatus, 0);
    checkSpacing("R10 spacing id");
  endtask

  task automatic t_program();
    runOp(2'd3, 16'h0013, 8'h3C, 1'b1);
    check(nWr - wr0 == 4, "R5/R11 write count (busy request ignored)", nWr - wr0, 4);
    checkWr(0, 16'h5555, 8'hAA, "R5 unlock1");
    checkWr(1, 16'h2AAA, 8'h55, "R5 unlock2");
    checkWr(2, 16'h5555, 8'hA0, "R5 program cmd");
    checkWr(3, 16'h0013, 8'h3C, "R5 data write");
    check(nRd - rd0 == 6, "R12 reads: blank+4 polls+verify", nRd - rd0, 6);
    check(mem[8'h13] == 8'h3C, "R5 stored byte", mem[8'h13], 8'h3C);
    check(lastStatus == 2'd0, "R5 status", lastStatus, 0);
    checkSpacing("R10 spacing program");
  endtask

  task automatic t_skipFF();
    runOp(2'd3, 16'h0050, 8'hFF, 1'b0);
    check(nWr == wr0 && nRd == rd0, "R6 no bus cycles", (nWr - wr0) + (nRd - rd0), 0);
    check(lat == 1, "R6 ack latency", lat, 1);
    check(lastStatus == 2'd0, "R6 status", lastStatus, 0);
  endtask

  task automatic t_notBlank();
    runOp(2'd3, 16'h0013, 8'h11, 1'b0);
    check(lastStatus == 2'd1, "R7 status", lastStatus, 1);
    check(nWr == wr0, "R7 no writes", nWr - wr0, 0);
    check(nRd - rd0 == 1, "R7 one read", nRd - rd0, 1);
    check(mem[8'h13] == 8'h3C, "R7 byte untouched", mem[8'h13], 8'h3C);
  endtask

  task automatic t_sectorErase();
    runOp(2'd3, 16'h0023, 8'h77, 1'b0);
    check(lastStatus == 2'd0, "R5 setup program status", lastStatus, 0);
    runOp(2'd1, 16'h0010, 8'h00, 1'b0);
    check(nWr - wr0 == 6, "R3 write count", nWr - wr0, 6);
    checkWr(2, 16'h5555, 8'h80, "R3 setup cmd");
    checkWr(3, 16'h5555, 8'hAA, "R3 second unlock1");
    checkWr(4, 16'h2AAA, 8'h55, "R3 second unlock2");
    checkWr(5, 16'h0010, 8'h30, "R3 sector cmd");
    check(mem[8'h13] == 8'hFF, "R3 sector erased", mem[8'h13], 8'hFF);
    check(mem[8'h23] == 8'h77, "R3 other sector kept", mem[8'h23], 8'h77);
    check(lastStatus == 2'd0, "R3 status", lastStatus, 0);
  endtask

  task automatic t_verify();
    fault = 1'b1;
    runOp(2'd3, 16'h0030, 8'h5A, 1'b0);
    fault = 1'b0;
    check(lastStatus == 2'd2, "R8 verify mismatch status", lastStatus, 2);
  endtask

  task automatic t_chipErase();
    runOp(2'd2, 16'h0000, 8'h00, 1'b0);
    check(nWr - wr0 == 6, "R4 write count", nWr - wr0, 6);
    checkWr(2, 16'h5555, 8'h80, "R4 setup cmd");
    checkWr(5, 16'h5555, 8'h10, "R4 chip cmd");
    check(mem[8'h23] == 8'hFF && mem[8'h30] == 8'hFF, "R4 all erased",
          {mem[8'h23], mem[8'h30]}, 16'hFFFF);
    check(lastStatus == 2'd0, "R4 status", lastStatus, 0);
  endtask

  task automatic t_timeout();
    stuck = 1'b1;
    runOp(2'd3, 16'h0040, 8'h12, 1'b0);
    check(lastStatus == 2'd3, "R9 timeout status", lastStatus, 3);
    check(nRd - rd0 == 1 + POLLS, "R9 reads: blank+MAX_POLLS, no verify", nRd - rd0, 1 + POLLS);
    check(nWr - wr0 == 4, "R9 write count", nWr - wr0, 4);
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_readId();
    t_program();
    t_skipFF();
    t_notBlank();
    t_sectorErase();
    t_verify();
    t_chipErase();
    t_timeout();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule